// File: doc/BRIEF.md
# Photodiode Threshold Calibration Sequencer

This controller finds a detection threshold for a light sensor. It steps a DAC code upward from zero, one code per step. After each write it waits a programmable settling time and then inspects a comparator that watches the sensor. The comparator input is asynchronous. The first code at which the comparator trips is recorded under bright illumination.

After the bright trip, the sequencer raises a request and stalls so that the host can change the illumination. When the host pulses a ready input, the sequencer repeats the ramp under dark conditions and records a second trip code. It then writes the midpoint of the two recorded codes to the DAC and reports success. If a ramp reaches full scale without a trip, the sequencer writes zero to the DAC and reports failure instead.

The DAC serial link, the comparator and the sensor are outside this block. The block only presents a code and a one-cycle write strobe for each new value.

Top module: `pd_thresh_cal`

## Requirements
- R1: While reset is applied and right after it, `dac_code_o` is 0 and `dac_wr_o`, `phase_req_o`, `done_o` and `fail_o` are all low.
- R2: A `start_i` pulse in idle clears `done_o` and `fail_o` and begins the bright ramp. The ramp writes codes 0, 1, 2, … in order, and each write is a one-cycle `dac_wr_o` pulse. `dac_code_o` changes only in a cycle where `dac_wr_o` is high.
- R3: Within a ramp, consecutive `dac_wr_o` pulses are exactly `settle_cycles_i` + 4 cycles apart. The same spacing applies from the last ramp write to the final write.
- R4: The comparator passes through a two-flop synchronizer. It counts as tripped only when it reads high on two consecutive sampling cycles that follow the settling time. An input that toggles every cycle never trips.
- R5: After a bright trip, `phase_req_o` stays high and no write occurs until a one-cycle `phase_ready_i` pulse arrives.
- R6: After `phase_ready_i`, the dark ramp restarts at code 0 and steps upward exactly as the bright ramp does.
- R7: After the dark trip, the block makes one final write of floor((bright + dark) / 2), formed from a 13-bit sum (for example 4095 and 4094 give 4094). `done_o` then goes high and stays high until the next start, while `fail_o` stays low.
- R8: If either ramp writes code 4095 without a trip, the final write is code 0. `fail_o` then goes high and stays high until the next start, while `done_o` stays low.
- R9: `start_i` has no effect while a calibration run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a calibration run |
| settle_cycles_i | input | 8 | Settling wait after each DAC write, in cycles |
| cmp_i | input | 1 | Asynchronous comparator output, high means tripped |
| phase_ready_i | input | 1 | One-cycle pulse: dark illumination is in place |
| phase_req_o | output | 1 | High while waiting for the illumination change |
| dac_code_o | output | 12 | Code presented to the DAC |
| dac_wr_o | output | 1 | One-cycle strobe marking a new DAC code |
| done_o | output | 1 | Run finished with the midpoint written |
| fail_o | output | 1 | Run ended because a ramp reached full scale untripped |

## Verification
The bench drives trips at code 0 and at full scale. A design that compares for the trip before the code reaches the DAC would skip code 0, and a 12-bit midpoint sum would wrap and write 2046 instead of 4094. It also feeds a comparator that toggles every cycle just below the threshold. A design that accepts a single high sample would then record a code that is too low. Untripped ramps in both phases check that the run ends with code 0 and the failure flag rather than a stale code. A start pulse in the middle of a ramp must leave the sequence of written codes unchanged.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_SAMP0,
    ST_SAMP1,
    ST_PHASE,
    ST_LAST
  } ptc_state_e;
endpackage

// File: rtl/ptc_cmp_sync.sv
module ptc_cmp_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_async_i,
  output logic level_o,
  output logic pair_hi_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= cmp_async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level_o   = s2_q;
  // high when the synchronized level was high in this cycle and the previous one
  assign pair_hi_o = s2_q & s3_q;
endmodule

// File: rtl/ptc_settle_timer.sv
module ptc_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  a_r3_settle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && len_i != '0) |=> !expired_o);
endmodule

// File: rtl/ptc_trip_store.sv
module ptc_trip_store #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_bright_i,
  input  logic              cap_dark_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] bright_o,
  output logic [CODE_W-1:0] dark_o,
  output logic [CODE_W-1:0] mid_o
);
  localparam int SUM_W = CODE_W + 1;

  function automatic logic [CODE_W-1:0] midpoint(input logic [CODE_W-1:0] a,
                                                 input logic [CODE_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[SUM_W-1:1];
  endfunction

  logic [CODE_W-1:0] bright_q, dark_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bright_q <= '0;
      dark_q   <= '0;
    end else begin
      if (cap_bright_i) bright_q <= code_i;
      if (cap_dark_i)   dark_q   <= code_i;
    end
  end

  assign bright_o = bright_q;
  assign dark_o   = dark_q;
  // midpoint of the stored bright code and the code being captured as dark
  assign mid_o    = midpoint(bright_q, code_i);
endmodule

// File: rtl/pd_thresh_cal.sv
module pd_thresh_cal #(
  parameter int CODE_W   = 12,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                cmp_i,
  input  logic                phase_ready_i,
  output logic                phase_req_o,
  output logic [CODE_W-1:0]   dac_code_o,
  output logic                dac_wr_o,
  output logic                done_o,
  output logic                fail_o
);
  import ptc_pkg::*;

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  ptc_state_e        state_q;
  logic [CODE_W-1:0] code_q;
  logic              dark_q, miss_q, done_q, fail_q;

  // named internal events
  logic              cmp_lvl, cmp_pair, settle_exp;
  logic              trip_ev, ramp_end, cap_bright, cap_dark;
  logic [CODE_W-1:0] st_bright, st_dark, st_mid;

  ptc_cmp_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cmp_async_i(cmp_i),
    .level_o(cmp_lvl), .pair_hi_o(cmp_pair)
  );

  ptc_settle_timer #(.W(SETTLE_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .load_i(state_q == ST_WRITE),
    .len_i(settle_cycles_i), .expired_o(settle_exp)
  );

  assign trip_ev    = (state_q == ST_SAMP1) && cmp_pair;
  assign ramp_end   = (code_q == CODE_MAX);
  assign cap_bright = trip_ev && !dark_q;
  assign cap_dark   = trip_ev && dark_q;

  ptc_trip_store #(.CODE_W(CODE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_bright_i(cap_bright), .cap_dark_i(cap_dark),
    .code_i(code_q), .bright_o(st_bright), .dark_o(st_dark), .mid_o(st_mid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      dark_q  <= 1'b0;
      miss_q  <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          code_q  <= '0;
          dark_q  <= 1'b0;
          miss_q  <= 1'b0;
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
          state_q <= ST_WRITE;
        end
        ST_WRITE:  state_q <= ST_SETTLE;
        ST_SETTLE: if (settle_exp) state_q <= ST_SAMP0;
        ST_SAMP0:  state_q <= ST_SAMP1;
        ST_SAMP1: begin
          if (trip_ev) begin
            if (!dark_q) state_q <= ST_PHASE;
            else begin
              code_q  <= st_mid;
              state_q <= ST_LAST;
            end
          end else if (ramp_end) begin
            code_q  <= '0;
            miss_q  <= 1'b1;
            state_q <= ST_LAST;
          end else begin
            code_q  <= code_q + 1'b1;
            state_q <= ST_WRITE;
          end
        end
        ST_PHASE: if (phase_ready_i) begin
          code_q  <= '0;
          dark_q  <= 1'b1;
          state_q <= ST_WRITE;
        end
        ST_LAST: begin
          if (miss_q) fail_q <= 1'b1;
          else        done_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dac_code_o  = code_q;
  assign dac_wr_o    = (state_q == ST_WRITE) || (state_q == ST_LAST);
  assign phase_req_o = (state_q == ST_PHASE);
  assign done_o      = done_q;
  assign fail_o      = fail_q;

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    dac_wr_o |=> !dac_wr_o);

  a_r2_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_o |-> $stable(dac_code_o));

  a_r5_phase_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_req_o && !phase_ready_i) |=> (phase_req_o && !dac_wr_o));

  a_r7_mid_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ((dac_code_o >= st_bright && dac_code_o <= st_dark) ||
                       (dac_code_o <= st_bright && dac_code_o >= st_dark)));

  a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  a_r8_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> (dac_code_o == '0));

  a_r4_trip_level: assert property (@(posedge clk) disable iff (!rst_n)
    trip_ev |-> (cmp_lvl && $past(cmp_lvl)));
endmodule

// File: tb/pd_thresh_cal_tb_top.sv
module pd_thresh_cal_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [7:0] settle_cycles_i = 8'd0;
  logic cmp_i = 1'b0;
  logic phase_ready_i = 1'b0;
  logic phase_req_o, dac_wr_o, done_o, fail_o;
  logic [11:0] dac_code_o;

  always #2 clk = ~clk;

  pd_thresh_cal dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_cycles_i(settle_cycles_i),
    .cmp_i(cmp_i), .phase_ready_i(phase_ready_i), .phase_req_o(phase_req_o),
    .dac_code_o(dac_code_o), .dac_wr_o(dac_wr_o), .done_o(done_o), .fail_o(fail_o)
  );

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int last_code = 0;
  int gap = 0;
  bit gap_valid = 0;
  int cur_settle = 0;
  int thr = 5000;
  bit noise_en = 0;
  int noise_lo = 0;
  bit tog = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // comparator model: trips at or above thr; optional toggling window below thr
  always @(negedge clk) begin
    tog <= ~tog;
    if (noise_en && int'(dac_code_o) >= noise_lo && int'(dac_code_o) < thr) cmp_i <= tog;
    else cmp_i <= (int'(dac_code_o) >= thr);
  end

  // reference scoreboard, compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      gap++;
      if (phase_req_o) gap_valid = 0;
      if (dac_wr_o) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected write", int'(dac_code_o), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(int'(dac_code_o) == e, "R2 written code", int'(dac_code_o), e);
        end
        if (gap_valid) check(gap == cur_settle + 4, "R3 write spacing", gap, cur_settle + 4);
        gap = 0;
        gap_valid = 1;
        last_code = int'(dac_code_o);
      end else if (int'(dac_code_o) != last_code) begin
        check(0, "R2 code changed without strobe", int'(dac_code_o), last_code);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(input int tb, input int td, input int s, input bit nz,
                     input int wait_cyc, input bit poke, input string tag);
    bit exp_fail;
    int fin;
    int n;
    exp_fail = 0;
    for (int c = 0; c <= ((tb > 4095) ? 4095 : tb); c++) exp_q.push_back(c);
    if (tb > 4095) begin
      exp_fail = 1; fin = 0;
    end else begin
      for (int c = 0; c <= ((td > 4095) ? 4095 : td); c++) exp_q.push_back(c);
      if (td > 4095) begin
        exp_fail = 1; fin = 0;
      end else fin = (tb + td) / 2;
    end
    exp_q.push_back(fin);
    settle_cycles_i = 8'(s);
    cur_settle = s;
    thr = tb;
    noise_en = nz;
    noise_lo = tb - 30;
    gap_valid = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (poke) begin
      // R9: a start pulse mid-ramp must not disturb the written sequence
      repeat (50) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    if (tb <= 4095) begin
      n = 0;
      while (!phase_req_o && n < 60000) begin @(negedge clk); n++; end
      check(phase_req_o, {tag, " R5 phase request"}, phase_req_o, 1);
      for (int k = 0; k < wait_cyc; k++) begin
        @(negedge clk);
        check(phase_req_o && !dac_wr_o, {tag, " R5 stall"}, dac_wr_o, 0);
      end
      noise_en = 0;
      thr = td;
      phase_ready_i = 1'b1;
      @(negedge clk) phase_ready_i = 1'b0;
    end
    n = 0;
    while (!(done_o || fail_o) && n < 60000) begin @(negedge clk); n++; end
    @(negedge clk);
    // R6: the whole bright and dark sequences were consumed in order
    check(exp_q.size() == 0, {tag, " R6 sequence complete"}, exp_q.size(), 0);
    check(fail_o == exp_fail, {tag, " R8 fail flag"}, fail_o, exp_fail);
    check(done_o == !exp_fail, {tag, " R7 done flag"}, done_o, !exp_fail);
    check(int'(dac_code_o) == fin, {tag, " R7 final code"}, int'(dac_code_o), fin);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dac_code_o == 12'd0 && !dac_wr_o, "R1 code during reset", int'(dac_code_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done_o && !fail_o && !phase_req_o && !dac_wr_o, "R1 flags after reset",
          int'({done_o, fail_o, phase_req_o, dac_wr_o}), 0);
    check(dac_code_o == 12'd0, "R1 code after reset", int'(dac_code_o), 0);
    run(100, 300, 2, 0, 10, 0, "R7 basic");
    run(0, 0, 0, 0, 1, 0, "R2 trip at zero");
    run(4095, 4094, 0, 0, 3, 0, "R7 wide sum");
    run(5000, 0, 0, 0, 0, 0, "R8 bright miss");
    run(60, 7, 1, 1, 5, 1, "R4 noise R9");
    run(20, 5000, 3, 0, 2, 0, "R8 dark miss");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule